// File: doc/BRIEF.md
# Serial Word Exchange Master

This block is the controller side of a four-wire synchronous serial link. The system side presents a parallel word, a one-hot choice of target device and a start strobe. The block then selects the chosen device by pulling its active-low select line, runs the serial clock and the outgoing data line, and samples the incoming data line. When the exchange is complete it returns the word that was shifted in and raises a single-cycle completion pulse.

One shift engine covers all four combinations of clock idle level (polarity) and sampling phase. The two mode bits and a half-period count for the serial clock are run-time inputs and are captured when a transfer starts. Each serial clock half-period lasts a programmable number of system clock cycles, with zero treated as one. The word length, the number of select lines and the divider width are parameters.

Top module: `spi_word_master`

## Requirements
- R1: After reset every select line is high, the serial clock is low, and busy and done are both low.
- R2: Whenever no transfer is running the serial clock sits at the level of the polarity input (0 or 1), and it is still at that level when the select line falls.
- R3: A transfer pulls low only the select line whose bit is set in the one-hot select input (bit i drives line i). That line falls one half-period before the first clock edge and rises one half-period after the last edge. All other lines stay high.
- R4: Each transfer produces exactly 2×WORD_W serial clock edges. Consecutive edges are exactly one half-period apart, where the half-period is the latched divider count in system cycles, with 0 treated as 1.
- R5: The outgoing word leaves most-significant bit first. With phase 0 the device samples on the edge leaving the idle level and new data appears on the edge returning to it. With phase 1 the two edges swap roles. A device that follows this rule receives exactly the transmitted word in all four modes.
- R6: On each sampling edge the incoming bit enters the least-significant end of the shift register, so the returned word equals the device's word with its first-sent bit as MSB, in all four modes.
- R7: With phase 0 the most-significant outgoing bit is already on the data output in the cycle the select line falls.
- R8: Done is high for exactly one cycle, (2×WORD_W+1) half-periods after the select line falls, and busy is low in that cycle. The returned word is valid from that pulse and stays unchanged until the next transfer completes.
- R9: A start request while busy is ignored. The word, the selection and the mode inputs can change during a transfer without affecting it.
- R10: A start request in the cycle done is high is accepted. The select line is then high for exactly one cycle between the two transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | Request to begin a transfer, taken when idle |
| txWord | input | WORD_W | Word to transmit |
| selOneHot | input | NUM_SEL | One-hot choice of target select line |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | Sampling phase selector |
| halfDiv | input | DIV_W | Serial clock half-period in system cycles (0 acts as 1) |
| miso | input | 1 | Serial data from the device |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rxWord | output | WORD_W | Word received in the last transfer |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the device |
| ssN | output | NUM_SEL | Active-low select lines |

## Verification
The completion of one transfer and the acceptance of the next can meet on the same system clock edge. The edge after the done pulse both captures a new word into the shift register and must leave the returned word intact. The bench holds the start request high from the first transfer through its done pulse. It then checks that the first returned word survives while the second transfer runs, that the select line is high for exactly one cycle, and that the second exchange delivers its own word correctly. A separate scenario raises a start request and flips the mode inputs in the middle of a transfer. It checks that only one done pulse appears and that the edge count and both exchanged words are correct.

// File: rtl/spi_word_pkg.sv
package spi_word_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_TAIL = 2'd2
  } xferState_t;

  typedef struct packed {
    logic load;    // begin a transfer: latch word, mode and selection
    logic toggle;  // emit one serial clock edge
    logic lead;    // this edge leaves the idle level
    logic finish;  // release select, publish received word
  } ctrlStb_t;

endpackage

// File: rtl/spi_word_ctrl.sv
module spi_word_ctrl
  import spi_word_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [DIV_W-1:0] halfDiv,
  output logic             busy,
  output ctrlStb_t         stb
);

  localparam int EDGES = 2 * WORD_W;
  localparam int ECW   = $clog2(EDGES + 1);

  xferState_t       state;
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] halfQ;
  logic [DIV_W-1:0] halfEff;
  logic [ECW-1:0]   edgeCnt;
  logic             tick;
  logic             lastEdge;

  assign halfEff  = (halfDiv == '0) ? DIV_W'(1) : halfDiv;
  assign tick     = (divCnt == '0);
  assign lastEdge = (edgeCnt == ECW'(EDGES - 1));
  assign busy     = (state != ST_IDLE);

  always_comb begin
    stb        = '0;
    stb.load   = (state == ST_IDLE) && startReq;
    stb.toggle = (state == ST_RUN) && tick;
    stb.lead   = (state == ST_RUN) && tick && !edgeCnt[0];
    stb.finish = (state == ST_TAIL) && tick;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      divCnt  <= '0;
      halfQ   <= DIV_W'(1);
      edgeCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (startReq) begin
          halfQ   <= halfEff;
          divCnt  <= halfEff - DIV_W'(1);
          edgeCnt <= '0;
          state   <= ST_RUN;
        end
        ST_RUN: if (tick) begin
          divCnt  <= halfQ - DIV_W'(1);
          edgeCnt <= edgeCnt + ECW'(1);
          if (lastEdge) state <= ST_TAIL;
        end else begin
          divCnt <= divCnt - DIV_W'(1);
        end
        ST_TAIL: if (tick) state <= ST_IDLE;
                 else divCnt <= divCnt - DIV_W'(1);
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4: never more edges than one word needs
  a_r4_edge_limit: assert property (@(posedge clk) disable iff (!rstN)
    edgeCnt <= ECW'(EDGES));

  // R4: the divider never runs past the latched half-period
  a_r4_div_bound: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> divCnt < halfQ);

endmodule

// File: rtl/spi_word_dp.sv
module spi_word_dp
  import spi_word_pkg::*;
#(
  parameter int WORD_W  = 8,
  parameter int NUM_SEL = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStb_t           stb,
  input  logic               busy,
  input  logic [WORD_W-1:0]  txWord,
  input  logic [NUM_SEL-1:0] selOneHot,
  input  logic               cpol,
  input  logic               cpha,
  input  logic               miso,
  output logic               sclk,
  output logic               mosi,
  output logic [NUM_SEL-1:0] ssN,
  output logic [WORD_W-1:0]  rxWord,
  output logic               done
);

  localparam int MSB = WORD_W - 1;

  logic [WORD_W-1:0]  shiftQ;
  logic [WORD_W-1:0]  rxQ;
  logic [NUM_SEL-1:0] ssNQ;
  logic               sclkQ;
  logic               mosiQ;
  logic               doneQ;
  logic               cpolQ;
  logic               cphaQ;
  logic               captureEdge;

  // phase 0 samples on the leading edge, phase 1 on the trailing edge
  assign captureEdge = stb.lead ^ cphaQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ <= '0;
      rxQ    <= '0;
      ssNQ   <= '1;
      sclkQ  <= 1'b0;
      mosiQ  <= 1'b0;
      doneQ  <= 1'b0;
      cpolQ  <= 1'b0;
      cphaQ  <= 1'b0;
    end else begin
      doneQ <= stb.finish;
      if (stb.load) begin
        cpolQ  <= cpol;
        cphaQ  <= cpha;
        shiftQ <= txWord;
        mosiQ  <= cpha ? 1'b0 : txWord[MSB];
        sclkQ  <= cpol;
        ssNQ   <= ~selOneHot;
      end else if (stb.toggle) begin
        sclkQ <= ~sclkQ;
        if (captureEdge) shiftQ <= {shiftQ[MSB-1:0], miso};
        else             mosiQ  <= shiftQ[MSB];
      end else if (stb.finish) begin
        ssNQ <= '1;
        rxQ  <= shiftQ;
      end else if (!busy) begin
        sclkQ <= cpol;
      end
    end
  end

  assign sclk   = sclkQ;
  assign mosi   = mosiQ;
  assign ssN    = ssNQ;
  assign rxWord = rxQ;
  assign done   = doneQ;

  // R8: completion is a single-cycle pulse
  a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);

  // R9: latched mode bits hold for the whole transfer
  a_r9_mode_held: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> ($stable(cpolQ) && $stable(cphaQ)));

  // R3: at most one select line is active
  a_r3_sel_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~ssNQ));

  // R2: the clock starts a transfer at its idle level
  a_r2_idle_at_select: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> (sclkQ == cpolQ));

endmodule

// File: rtl/spi_word_master.sv
module spi_word_master
  import spi_word_pkg::*;
#(
  parameter int WORD_W  = 8,
  parameter int NUM_SEL = 4,
  parameter int DIV_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startReq,
  input  logic [WORD_W-1:0]  txWord,
  input  logic [NUM_SEL-1:0] selOneHot,
  input  logic               cpol,
  input  logic               cpha,
  input  logic [DIV_W-1:0]   halfDiv,
  input  logic               miso,
  output logic               busy,
  output logic               done,
  output logic [WORD_W-1:0]  rxWord,
  output logic               sclk,
  output logic               mosi,
  output logic [NUM_SEL-1:0] ssN
);

  ctrlStb_t stb;

  spi_word_ctrl #(.WORD_W(WORD_W), .DIV_W(DIV_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .halfDiv  (halfDiv),
    .busy     (busy),
    .stb      (stb)
  );

  spi_word_dp #(.WORD_W(WORD_W), .NUM_SEL(NUM_SEL)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .busy      (busy),
    .txWord    (txWord),
    .selOneHot (selOneHot),
    .cpol      (cpol),
    .cpha      (cpha),
    .miso      (miso),
    .sclk      (sclk),
    .mosi      (mosi),
    .ssN       (ssN),
    .rxWord    (rxWord),
    .done      (done)
  );

  // R8: busy has dropped by the time done is seen
  a_r8_done_not_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

endmodule

// File: tb/spi_word_master_tb.sv
module spi_word_master_tb;

  localparam int W = 8;
  localparam int S = 4;
  localparam int D = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         startReq = 1'b0;
  logic [W-1:0] txWord = '0;
  logic [S-1:0] selOneHot = '0;
  logic         cpol = 1'b0;
  logic         cpha = 1'b0;
  logic [D-1:0] halfDiv = '0;
  logic         miso;
  logic         busy, done, sclk, mosi;
  logic [W-1:0] rxWord;
  logic [S-1:0] ssN;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // slave model state
  bit           tbCpol, tbCpha;
  int           effHalf = 1;
  int           selIdx = 0;
  logic [W-1:0] slvWord = '0, slvShift = '0, slvRx = '0;
  logic         misoQ = 1'b0;
  bit           prevSel = 1'b0;
  logic         prevSclk = 1'b0;
  int           edgeCount = 0, lastEdgeCyc = 0, ssFallCyc = 0, doneCount = 0;
  bit           spacingBad = 1'b0, otherSel = 1'b0;
  logic         sclkAtFall = 1'b0, mosiAtFall = 1'b0;

  assign miso = misoQ;

  always #4 clk = ~clk;

  spi_word_master #(.WORD_W(W), .NUM_SEL(S), .DIV_W(D)) u_dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .txWord(txWord),
    .selOneHot(selOneHot), .cpol(cpol), .cpha(cpha), .halfDiv(halfDiv),
    .miso(miso), .busy(busy), .done(done), .rxWord(rxWord),
    .sclk(sclk), .mosi(mosi), .ssN(ssN)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // device model, evaluated 2 ns after each rising edge
  always @(posedge clk) begin
    bit selLow;
    #2;
    if (done) doneCount++;
    selLow = (ssN[selIdx] == 1'b0);
    if (selLow && !prevSel) begin
      ssFallCyc   = cyc;
      lastEdgeCyc = cyc;
      edgeCount   = 0;
      slvShift    = slvWord;
      slvRx       = '0;
      sclkAtFall  = sclk;
      mosiAtFall  = mosi;
      if (!tbCpha) misoQ = slvShift[W-1];
    end
    if (selLow) begin
      if (((~ssN) & ~(S'(1) << selIdx)) != '0) otherSel = 1'b1;
      if (sclk !== prevSclk) begin
        bit isLead;
        edgeCount++;
        if (cyc - lastEdgeCyc != effHalf) spacingBad = 1'b1;
        lastEdgeCyc = cyc;
        isLead = (prevSclk == tbCpol);
        if (isLead ^ tbCpha) begin
          slvRx = {slvRx[W-2:0], mosi};
        end else if (tbCpha) begin
          misoQ    = slvShift[W-1];
          slvShift = slvShift << 1;
        end else begin
          slvShift = slvShift << 1;
          misoQ    = slvShift[W-1];
        end
      end
    end
    prevSclk = sclk;
    prevSel  = selLow;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic testReset();
    check(ssN == '1, "R1", "select lines after reset", ssN, {S{1'b1}});
    check(sclk == 1'b0, "R1", "sclk after reset", sclk, 0);
    check(busy == 1'b0, "R1", "busy after reset", busy, 0);
    check(done == 1'b0, "R1", "done after reset", done, 0);
  endtask

  task automatic waitDone(output bit seen);
    int n = 0;
    seen = 1'b0;
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
    end
    seen = done;
  endtask

  // one transfer; disturb raises a start and flips inputs mid-transfer (R9)
  task automatic runXfer(input bit pol, input bit pha, input int half,
                         input int sel, input logic [W-1:0] tx,
                         input logic [W-1:0] slv, input bit disturb);
    int d0, n;
    bit seen;
    @(negedge clk);
    cpol = pol; cpha = pha; tbCpol = pol; tbCpha = pha;
    repeat (2) @(negedge clk);
    check(sclk == pol, "R2", "idle sclk before start", sclk, pol);
    effHalf = (half == 0) ? 1 : half;
    selIdx = sel; slvWord = slv; halfDiv = D'(half);
    selOneHot = S'(1) << sel; txWord = tx;
    spacingBad = 1'b0; otherSel = 1'b0; d0 = doneCount;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    n = 0;
    seen = 1'b0;
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
      if (disturb && n == 5) begin
        startReq = 1'b1; txWord = ~tx; cpol = ~pol; cpha = ~pha;
        selOneHot = S'(1) << ((sel + 1) % S);
      end
      if (disturb && n == 6) startReq = 1'b0;
    end
    seen = done;
    check(seen, "R8", "done pulse seen", seen, 1);
    check(rxWord == slv, "R6", "received word", rxWord, slv);
    check(slvRx == tx, "R5", "word seen by device", slvRx, tx);
    check(edgeCount == 2 * W, "R4", "edge count", edgeCount, 2 * W);
    check(!spacingBad, "R4", "edge spacing", spacingBad, 0);
    check(cyc - ssFallCyc == (2 * W + 1) * effHalf, "R8", "done latency",
          cyc - ssFallCyc, (2 * W + 1) * effHalf);
    check(!busy, "R8", "busy low with done", busy, 0);
    check(sclk == pol, "R2", "sclk idle at end", sclk, pol);
    check(sclkAtFall == pol, "R2", "sclk at select fall", sclkAtFall, pol);
    if (!pha) check(mosiAtFall == tx[W-1], "R7", "first bit at select fall",
                    mosiAtFall, tx[W-1]);
    check(!otherSel, "R3", "unselected lines stay high", otherSel, 0);
    check(ssN == '1, "R3", "select released", ssN, {S{1'b1}});
    @(negedge clk);
    check(!done, "R8", "done lasts one cycle", done, 0);
    check(doneCount - d0 == 1, disturb ? "R9" : "R8", "done pulses per transfer",
          doneCount - d0, 1);
    cpol = pol; cpha = pha;
  endtask

  // R10: start held through done; next transfer begins at once
  task automatic testBackToBack();
    bit seen, held;
    int n;
    @(negedge clk);
    cpol = 1'b1; cpha = 1'b0; tbCpol = 1'b1; tbCpha = 1'b0;
    repeat (2) @(negedge clk);
    effHalf = 2; halfDiv = D'(2); selIdx = 3; selOneHot = 4'b1000;
    slvWord = 8'h3C; txWord = 8'hA7; startReq = 1'b1;
    waitDone(seen);
    check(seen && rxWord == 8'h3C, "R10", "first word of pair", rxWord, 8'h3C);
    check(ssN[3] == 1'b1, "R10", "select high after first done", ssN[3], 1);
    slvWord = 8'hD2; txWord = 8'h19;
    @(negedge clk);
    startReq = 1'b0;
    check(ssN[3] == 1'b0, "R10", "select low one cycle later", ssN[3], 0);
    held = 1'b1;
    n = 0;
    while (!done && n < 20000) begin
      if (rxWord != 8'h3C) held = 1'b0;
      @(negedge clk);
      n++;
    end
    check(held, "R8", "returned word held until next done", held, 1);
    check(rxWord == 8'hD2, "R10", "second word received", rxWord, 8'hD2);
    check(slvRx == 8'h19, "R10", "second word sent", slvRx, 8'h19);
    check(edgeCount == 2 * W, "R10", "second edge count", edgeCount, 2 * W);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: run did not complete");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    runXfer(1'b0, 1'b0, 2, 0, 8'hA5, 8'h5A, 1'b0);
    runXfer(1'b0, 1'b1, 2, 1, 8'h81, 8'h7E, 1'b0);
    runXfer(1'b1, 1'b0, 2, 2, 8'hC3, 8'h96, 1'b0);
    runXfer(1'b1, 1'b1, 2, 3, 8'h0F, 8'hF1, 1'b0);
    runXfer(1'b0, 1'b0, 0, 1, 8'h6D, 8'hB2, 1'b0);
    runXfer(1'b1, 1'b1, 3, 2, 8'h12, 8'hED, 1'b0);
    runXfer(1'b0, 1'b1, 2, 0, 8'h5B, 8'hA4, 1'b1);
    runXfer(1'b1, 1'b0, 1, 3, 8'hFF, 8'h00, 1'b1);
    testBackToBack();
    repeat (4) @(negedge clk);
    finishRun();
  end

endmodule